// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block is a performance monitoring unit that sits beside a request-handling path in a large chip. It holds eight 64-bit counters. Software programs them through a flat register space: 32-bit control registers, plus 64-bit counter registers that can be read and written whole. Each counter picks what it counts with an 8-bit event code. Three codes are live: requests received, requests sent, and clock cycles.

A counter advances only when the global enable and its own enable bit are both set. Request events are also qualified before they reach the counters. A source-ID match filter, a target-ID match filter and a trace-tag qualifier are shared by both request channels. Each filter compares selected ID bits against a programmed value and ignores the bits its mask marks as don't-care.

When a counter wraps it sets a sticky status bit. Software clears that bit with a write-one-to-clear register. A single interrupt line reports every status bit whose mask bit allows it.

Top module: `evctr_unit`

## Requirements
- R1: After reset every counter, every status bit, the global enable, the counter enables, the event codes, the filters and the trace-tag enable are zero. The interrupt mask register (0x1C70) resets to all ones, so `irq` is low.
- R2: Counter n is read and written as one 64-bit word at address 0x1F00 + 8*n. A write to a counter in the same cycle as an increment of that counter loads exactly the written value.
- R3: A counter advances only when bit 0 of 0x1C00 (global enable) and bit n of 0x1C04 (counter n enable) are both set. Clearing either one holds its value.
- R4: The 8-bit event code of counter n is in the register at 0x1C80 + 4*(n/4), bits [8*(n%4)+7 : 8*(n%4)], and reads back there. Code 0x40 counts received requests, 0x5C counts sent requests, 0x78 counts every clock cycle, and any other code counts nothing.
- R5: The source-ID filter at 0x1C18 and the target-ID filter at 0x1C14 share one layout: the match value in bits [10:0], the enable in bit 11, and the mask in bits [22:12]. While a filter is enabled, a request counts only if its ID equals the match value in every bit whose mask bit is 0. A filter whose enable is clear passes every request. The filters apply to both request channels and never to the cycle event.
- R6: When bit 4 of 0x1C08 is set, only requests with their trace-tag bit set are counted.
- R7: A counter that wraps from all ones to zero sets status bit n, read at 0x1C78. Writes to 0x1C78 have no effect.
- R8: Writing 0x1C7C clears exactly the status bits written as one. A wrap in the same cycle as a clear of that bit leaves the bit set.
- R9: `irq` is high exactly when some status bit n is set while mask bit n of 0x1C70 is 0.
- R10: Address 0x1CF0 reads a fixed version value (parameter, default 0x00000030). Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 13 | Register byte address |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 64 | Write data; 32-bit registers use bits [31:0] |
| regRdData | output | 64 | Combinational read data for regAddr |
| rxValid | input | 1 | A received request is present this cycle |
| rxSrcId | input | 11 | Source ID of the received request |
| rxTgtId | input | 11 | Target ID of the received request |
| rxTag | input | 1 | Trace tag of the received request |
| txValid | input | 1 | A sent request is present this cycle |
| txSrcId | input | 11 | Source ID of the sent request |
| txTgtId | input | 11 | Target ID of the sent request |
| txTag | input | 1 | Trace tag of the sent request |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can collide in one cycle. A software load of a counter can meet that counter's increment, and a write-one-to-clear can meet the wrap that sets the same status bit. The first collision is provoked by writing a counter while it counts clock cycles. The check reads the counter at the falling edge right after the write and requires exactly the written value; after one more counting edge it requires that value plus one. The second collision is provoked by preloading a counter one below all ones and issuing the clear on the edge where it wraps. The check requires the status bit to still be set afterwards.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int NUM_CTR     = 8;
  localparam int CTR_W       = 64;
  localparam int REG_W       = 32;
  localparam int ID_W        = 11;
  localparam int SEL_W       = 8;
  localparam int ADDR_W      = 13;
  localparam int NUM_CHAN    = 2;
  localparam int SEL_PER_REG = REG_W / SEL_W;

  localparam logic [ADDR_W-1:0] A_GLOBAL = 13'h1C00;
  localparam logic [ADDR_W-1:0] A_CNTEN  = 13'h1C04;
  localparam logic [ADDR_W-1:0] A_TAG    = 13'h1C08;
  localparam logic [ADDR_W-1:0] A_TGTF   = 13'h1C14;
  localparam logic [ADDR_W-1:0] A_SRCF   = 13'h1C18;
  localparam logic [ADDR_W-1:0] A_MASK   = 13'h1C70;
  localparam logic [ADDR_W-1:0] A_STAT   = 13'h1C78;
  localparam logic [ADDR_W-1:0] A_CLR    = 13'h1C7C;
  localparam logic [ADDR_W-1:0] A_VER    = 13'h1CF0;
  localparam int SEL_BASE = 'h1C80;
  localparam int CNT_BASE = 'h1F00;

  localparam int GEN_BIT = 0;
  localparam int TAG_BIT = 4;

  localparam logic [SEL_W-1:0] EV_RX  = 8'h40;
  localparam logic [SEL_W-1:0] EV_TX  = 8'h5C;
  localparam logic [SEL_W-1:0] EV_CYC = 8'h78;

  // packed order matches the register layout: mask, enable, match value
  typedef struct packed {
    logic [ID_W-1:0] msk;
    logic            en;
    logic [ID_W-1:0] cmd;
  } filt_t;

  localparam int FILT_W = $bits(filt_t);

  typedef struct packed {
    logic                            globalEn;
    logic [NUM_CTR-1:0]              cntEn;
    logic [NUM_CTR-1:0][SEL_W-1:0]   evSel;
    logic [NUM_CTR-1:0]              cntWr;
    logic [CTR_W-1:0]                wrData;
    logic [NUM_CTR-1:0]              statClr;
    logic [NUM_CTR-1:0]              intMask;
    logic                            tagEn;
    filt_t                           srcFilt;
    filt_t                           tgtFilt;
  } ctrl_strb_t;

  function automatic logic [ADDR_W-1:0] cntAddr(input int n);
    return ADDR_W'(CNT_BASE + 8 * n);
  endfunction

  function automatic logic [ADDR_W-1:0] selAddr(input int n);
    return ADDR_W'(SEL_BASE + 4 * (n / SEL_PER_REG));
  endfunction

  function automatic logic filtPass(input filt_t f, input logic [ID_W-1:0] id);
    return !f.en || (((id ^ f.cmd) & ~f.msk) == '0);
  endfunction
endpackage

// File: rtl/evctr_ctrl.sv
module evctr_ctrl
  import evctr_pkg::*;
#(
  parameter logic [REG_W-1:0] VERSION_ID = 32'h0000_0030
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic                           regWrEn,
  input  logic [CTR_W-1:0]               regWrData,
  input  logic [NUM_CTR-1:0][CTR_W-1:0]  cntVal,
  input  logic [NUM_CTR-1:0]             statusVal,
  output ctrl_strb_t                     strb,
  output logic [CTR_W-1:0]               regRdData
);
  logic                          globalEn;
  logic [NUM_CTR-1:0]            cntEnR;
  logic [NUM_CTR-1:0][SEL_W-1:0] evSelR;
  logic [NUM_CTR-1:0]            maskR;
  logic                          tagEnR;
  filt_t                         srcF;
  filt_t                         tgtF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      cntEnR   <= '0;
      evSelR   <= '0;
      maskR    <= '1;
      tagEnR   <= 1'b0;
      srcF     <= '0;
      tgtF     <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_GLOBAL) globalEn <= regWrData[GEN_BIT];
      if (regAddr == A_CNTEN)  cntEnR   <= regWrData[NUM_CTR-1:0];
      if (regAddr == A_MASK)   maskR    <= regWrData[NUM_CTR-1:0];
      if (regAddr == A_TAG)    tagEnR   <= regWrData[TAG_BIT];
      if (regAddr == A_SRCF)   srcF     <= filt_t'(regWrData[FILT_W-1:0]);
      if (regAddr == A_TGTF)   tgtF     <= filt_t'(regWrData[FILT_W-1:0]);
      for (int n = 0; n < NUM_CTR; n++) begin
        if (regAddr == selAddr(n))
          evSelR[n] <= regWrData[SEL_W*(n%SEL_PER_REG) +: SEL_W];
      end
    end
  end

  always_comb begin
    strb.globalEn = globalEn;
    strb.cntEn    = cntEnR;
    strb.evSel    = evSelR;
    strb.wrData   = regWrData;
    strb.intMask  = maskR;
    strb.tagEn    = tagEnR;
    strb.srcFilt  = srcF;
    strb.tgtFilt  = tgtF;
    strb.statClr  = (regWrEn && regAddr == A_CLR) ? regWrData[NUM_CTR-1:0] : '0;
    for (int n = 0; n < NUM_CTR; n++)
      strb.cntWr[n] = regWrEn && (regAddr == cntAddr(n));
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_GLOBAL: regRdData[GEN_BIT]       = globalEn;
      A_CNTEN:  regRdData[NUM_CTR-1:0]   = cntEnR;
      A_TAG:    regRdData[TAG_BIT]       = tagEnR;
      A_SRCF:   regRdData[FILT_W-1:0]    = srcF;
      A_TGTF:   regRdData[FILT_W-1:0]    = tgtF;
      A_MASK:   regRdData[NUM_CTR-1:0]   = maskR;
      A_STAT:   regRdData[NUM_CTR-1:0]   = statusVal;
      A_VER:    regRdData[REG_W-1:0]     = VERSION_ID;
      default:  ;
    endcase
    for (int n = 0; n < NUM_CTR; n++) begin
      if (regAddr == selAddr(n))
        regRdData[SEL_W*(n%SEL_PER_REG) +: SEL_W] = evSelR[n];
      if (regAddr == cntAddr(n))
        regRdData = cntVal[n];
    end
  end
endmodule

// File: rtl/evctr_reqqual.sv
module evctr_reqqual
  import evctr_pkg::*;
(
  input  logic            reqValid,
  input  logic [ID_W-1:0] srcId,
  input  logic [ID_W-1:0] tgtId,
  input  logic            reqTag,
  input  filt_t           srcFilt,
  input  filt_t           tgtFilt,
  input  logic            tagEn,
  output logic            reqCount
);
  assign reqCount = reqValid && filtPass(srcFilt, srcId) && filtPass(tgtFilt, tgtId)
                    && (!tagEn || reqTag);
endmodule

// File: rtl/evctr_dp.sv
module evctr_dp
  import evctr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strb_t                     strb,
  input  logic [NUM_CHAN-1:0]            reqValid,
  input  logic [NUM_CHAN-1:0][ID_W-1:0]  reqSrcId,
  input  logic [NUM_CHAN-1:0][ID_W-1:0]  reqTgtId,
  input  logic [NUM_CHAN-1:0]            reqTag,
  output logic [NUM_CTR-1:0][CTR_W-1:0]  cntVal,
  output logic [NUM_CTR-1:0]             statusVal,
  output logic                           irq
);
  logic [NUM_CHAN-1:0] reqOk;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    evctr_reqqual u_qual (
      .reqValid (reqValid[c]),
      .srcId    (reqSrcId[c]),
      .tgtId    (reqTgtId[c]),
      .reqTag   (reqTag[c]),
      .srcFilt  (strb.srcFilt),
      .tgtFilt  (strb.tgtFilt),
      .tagEn    (strb.tagEn),
      .reqCount (reqOk[c])
    );
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic             hit;
    logic             inc;
    logic             wrap;
    logic [CTR_W-1:0] cntR;
    logic             statR;

    always_comb begin
      case (strb.evSel[i])
        EV_RX:   hit = reqOk[0];
        EV_TX:   hit = reqOk[1];
        EV_CYC:  hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end

    assign inc  = strb.globalEn && strb.cntEn[i] && hit;
    assign wrap = inc && !strb.cntWr[i] && (cntR == {CTR_W{1'b1}});

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntR  <= '0;
        statR <= 1'b0;
      end else begin
        if (strb.cntWr[i])  cntR <= strb.wrData;
        else if (inc)       cntR <= cntR + CTR_W'(1);
        statR <= wrap || (statR && !strb.statClr[i]);
      end
    end

    assign cntVal[i]    = cntR;
    assign statusVal[i] = statR;
  end

  assign irq = |(statusVal & ~strb.intMask);
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
  import evctr_pkg::*;
#(
  parameter logic [REG_W-1:0] VERSION_ID = 32'h0000_0030
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CTR_W-1:0]  regWrData,
  output logic [CTR_W-1:0]  regRdData,
  input  logic              rxValid,
  input  logic [ID_W-1:0]   rxSrcId,
  input  logic [ID_W-1:0]   rxTgtId,
  input  logic              rxTag,
  input  logic              txValid,
  input  logic [ID_W-1:0]   txSrcId,
  input  logic [ID_W-1:0]   txTgtId,
  input  logic              txTag,
  output logic              irq
);
  ctrl_strb_t                    strb;
  logic [NUM_CTR-1:0][CTR_W-1:0] cntVal;
  logic [NUM_CTR-1:0]            statusVal;

  evctr_ctrl #(.VERSION_ID(VERSION_ID)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .cntVal    (cntVal),
    .statusVal (statusVal),
    .strb      (strb),
    .regRdData (regRdData)
  );

  evctr_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqValid  ({txValid, rxValid}),
    .reqSrcId  ({txSrcId, rxSrcId}),
    .reqTgtId  ({txTgtId, rxTgtId}),
    .reqTag    ({txTag, rxTag}),
    .cntVal    (cntVal),
    .statusVal (statusVal),
    .irq       (irq)
  );
endmodule

// File: rtl/evctr_unit_chk.sv
module evctr_unit_chk
  import evctr_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          irq,
  input logic                          globalEn,
  input logic [NUM_CTR-1:0]            cntWr,
  input logic [CTR_W-1:0]              wrData,
  input logic [NUM_CTR-1:0]            statClr,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cntVal,
  input logic [NUM_CTR-1:0]            statusVal
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    // R7
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusVal[i]) |-> ($past(cntVal[i]) == {CTR_W{1'b1}}));
    // R2
    wr_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(cntWr[i]) |-> (cntVal[i] == $past(wrData)));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(globalEn) && !$past(cntWr[i])) |-> (cntVal[i] == $past(cntVal[i])));
  end

  // R8
  clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusVal) & ~statusVal & ~$past(statClr)) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusVal == '0) |-> !irq);
endmodule

bind evctr_unit evctr_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irq       (irq),
  .globalEn  (strb.globalEn),
  .cntWr     (strb.cntWr),
  .wrData    (strb.wrData),
  .statClr   (strb.statClr),
  .cntVal    (cntVal),
  .statusVal (statusVal)
);

// File: tb/evctr_unit_tb.sv
module evctr_unit_tb;
  import evctr_pkg::*;

  logic              clk;
  logic              rstN;
  logic [ADDR_W-1:0] regAddr;
  logic              regWrEn;
  logic [CTR_W-1:0]  regWrData;
  logic [CTR_W-1:0]  regRdData;
  logic              rxValid, txValid, rxTag, txTag;
  logic [ID_W-1:0]   rxSrcId, rxTgtId, txSrcId, txTgtId;
  logic              irq;

  int checks = 0;
  int fails  = 0;

  evctr_unit u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxValid(rxValid), .rxSrcId(rxSrcId), .rxTgtId(rxTgtId), .rxTag(rxTag),
    .txValid(txValid), .txSrcId(txSrcId), .txTgtId(txTgtId), .txTag(txTag),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  code;
    logic [31:0] srcF;
    logic [31:0] tgtF;
    logic [31:0] tt;
    logic        useTx;
    logic [10:0] sid;
    logic [10:0] tid;
    logic        tag;
    logic [7:0]  expCnt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'h40, 32'h0,    32'h0,   32'h0,  1'b0, 11'h000, 11'h000, 1'b0, 8'd4},
    '{8'h40, 32'h0,    32'h0,   32'h0,  1'b1, 11'h000, 11'h000, 1'b0, 8'd0},
    '{8'h5C, 32'h0,    32'h0,   32'h0,  1'b1, 11'h000, 11'h000, 1'b0, 8'd4},
    '{8'h40, 32'h923,  32'h0,   32'h0,  1'b0, 11'h123, 11'h000, 1'b0, 8'd4},
    '{8'h40, 32'h923,  32'h0,   32'h0,  1'b0, 11'h122, 11'h000, 1'b0, 8'd0},
    '{8'h40, 32'hF920, 32'h0,   32'h0,  1'b0, 11'h12A, 11'h000, 1'b0, 8'd4},
    '{8'h40, 32'h0,    32'h855, 32'h0,  1'b0, 11'h3FF, 11'h055, 1'b0, 8'd4},
    '{8'h40, 32'h0,    32'h855, 32'h0,  1'b0, 11'h000, 11'h056, 1'b0, 8'd0},
    '{8'h40, 32'h0,    32'h0,   32'h10, 1'b0, 11'h000, 11'h000, 1'b0, 8'd0},
    '{8'h40, 32'h0,    32'h0,   32'h10, 1'b0, 11'h000, 11'h000, 1'b1, 8'd4},
    '{8'h40, 32'h123,  32'h0,   32'h0,  1'b0, 11'h000, 11'h000, 1'b0, 8'd4},
    '{8'h33, 32'h0,    32'h0,   32'h0,  1'b0, 11'h000, 11'h000, 1'b0, 8'd0},
    '{8'h5C, 32'h923,  32'h0,   32'h0,  1'b1, 11'h123, 11'h000, 1'b0, 8'd4},
    '{8'h5C, 32'h923,  32'h0,   32'h0,  1'b1, 11'h124, 11'h000, 1'b0, 8'd0}
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse(input logic onTx, input int n);
    repeat (n) begin
      if (onTx) txValid = 1'b1; else rxValid = 1'b1;
      @(negedge clk);
    end
    rxValid = 1'b0; txValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    rxValid = 0; txValid = 0; rxTag = 0; txTag = 0;
    rxSrcId = '0; rxTgtId = '0; txSrcId = '0; txTgtId = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(cntAddr(0), v); check("R1 counter0 after reset", v, 64'h0);
    rd(cntAddr(7), v); check("R1 counter7 after reset", v, 64'h0);
    rd(A_STAT, v);     check("R1 status after reset", v, 64'h0);
    rd(A_MASK, v);     check("R1 mask after reset", v, 64'hFF);
    rd(A_GLOBAL, v);   check("R1 global enable after reset", v, 64'h0);
    check("R1 irq after reset", {63'h0, irq}, 64'h0);

    // R10 version and unmapped space
    rd(A_VER, v);      check("R10 version value", v, 64'h30);
    rd(13'h1C50, v);   check("R10 unmapped read", v, 64'h0);

    // R4 R5 R6 vector table on counter 0
    for (int k = 0; k < NV; k++) begin
      wr(A_GLOBAL, 64'h0);
      wr(A_SRCF, {32'h0, VEC[k].srcF});
      wr(A_TGTF, {32'h0, VEC[k].tgtF});
      wr(A_TAG, {32'h0, VEC[k].tt});
      wr(13'h1C80, {56'h0, VEC[k].code});
      wr(A_CNTEN, 64'h1);
      wr(cntAddr(0), 64'h0);
      wr(A_GLOBAL, 64'h1);
      rxSrcId = VEC[k].sid; rxTgtId = VEC[k].tid; rxTag = VEC[k].tag;
      txSrcId = VEC[k].sid; txTgtId = VEC[k].tid; txTag = VEC[k].tag;
      pulse(VEC[k].useTx, 4);
      wr(A_GLOBAL, 64'h0);
      rd(cntAddr(0), v);
      check($sformatf("R4/R5/R6 vector %0d count", k), v, {56'h0, VEC[k].expCnt});
    end
    wr(A_SRCF, 64'h0); wr(A_TGTF, 64'h0); wr(A_TAG, 64'h0);
    rxTag = 0; txTag = 0;

    // R2 64-bit counter access
    wr(cntAddr(3), 64'h0123_4567_89AB_CDEF);
    rd(cntAddr(3), v); check("R2 counter3 64-bit readback", v, 64'h0123_4567_89AB_CDEF);
    rd(cntAddr(4), v); check("R2 counter4 untouched", v, 64'h0);

    // R4 packing: counter 6 byte 2 of second select register
    wr(13'h1C84, 64'h005C_0000);
    rd(13'h1C84, v); check("R4 select register readback", v, 64'h005C_0000);
    wr(A_CNTEN, 64'h40);
    wr(A_GLOBAL, 64'h1);
    pulse(1'b1, 3);
    pulse(1'b0, 2);
    wr(A_GLOBAL, 64'h0);
    rd(cntAddr(6), v); check("R4 counter6 counts sent requests", v, 64'h3);

    // R3 enable gating with cycle event on counter 1
    wr(13'h1C80, 64'h0000_7800);
    wr(A_CNTEN, 64'h02);
    wr(cntAddr(1), 64'h0);
    repeat (5) @(negedge clk);
    rd(cntAddr(1), v); check("R3 global enable clear holds", v, 64'h0);
    wr(A_CNTEN, 64'h00);
    wr(A_GLOBAL, 64'h1);
    repeat (5) @(negedge clk);
    wr(A_GLOBAL, 64'h0);
    rd(cntAddr(1), v); check("R3 counter enable clear holds", v, 64'h0);
    wr(A_CNTEN, 64'h02);
    wr(A_GLOBAL, 64'h1);
    repeat (10) @(negedge clk);
    wr(A_GLOBAL, 64'h0);
    rd(cntAddr(1), v); check("R3 cycle count with both enables", v, 64'd11);

    // R2 write beats increment
    wr(A_GLOBAL, 64'h1);
    repeat (3) @(negedge clk);
    wr(cntAddr(1), 64'hAAAA_0000_0000_0005);
    rd(cntAddr(1), v); check("R2 write wins over increment", v, 64'hAAAA_0000_0000_0005);
    wr(A_GLOBAL, 64'h0);
    rd(cntAddr(1), v); check("R2 counting resumes after write", v, 64'hAAAA_0000_0000_0006);

    // R7 overflow on counter 2
    wr(13'h1C80, 64'h0078_0000);
    wr(A_CNTEN, 64'h04);
    wr(cntAddr(2), 64'hFFFF_FFFF_FFFF_FFFE);
    wr(A_MASK, 64'hFB);
    wr(A_GLOBAL, 64'h1);
    @(negedge clk);
    rd(A_STAT, v); check("R7 no status before wrap", v, 64'h0);
    check("R9 irq low before wrap", {63'h0, irq}, 64'h0);
    @(negedge clk);
    rd(A_STAT, v); check("R7 status set on wrap", v, 64'h04);
    rd(cntAddr(2), v); check("R7 counter wrapped to zero", v, 64'h0);
    check("R9 irq high for unmasked status", {63'h0, irq}, 64'h1);
    wr(A_GLOBAL, 64'h0);

    // R9 masking
    wr(A_MASK, 64'hFF);
    check("R9 irq low when masked", {63'h0, irq}, 64'h0);
    wr(A_MASK, 64'hFB);
    check("R9 irq high when unmasked", {63'h0, irq}, 64'h1);

    // R7 status read-only, R8 clear semantics
    wr(A_STAT, 64'h0);
    rd(A_STAT, v); check("R7 status write ignored", v, 64'h04);
    wr(A_CLR, 64'h01);
    rd(A_STAT, v); check("R8 clear of other bit keeps status", v, 64'h04);
    wr(A_CLR, 64'h04);
    rd(A_STAT, v); check("R8 clear removes status", v, 64'h0);
    check("R9 irq low after clear", {63'h0, irq}, 64'h0);

    // R8 wrap and clear in the same cycle
    wr(cntAddr(2), 64'hFFFF_FFFF_FFFF_FFFE);
    wr(A_GLOBAL, 64'h1);
    @(negedge clk);
    wr(A_CLR, 64'h04);
    rd(A_STAT, v); check("R8 wrap beats same-cycle clear", v, 64'h04);
    wr(A_GLOBAL, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule